// File: doc/BRIEF.md
# Rotating-Phase Pattern Memory Self-Test Engine

This block is a built-in self-test engine for a byte-wide, single-port synchronous RAM. Given an inclusive address window, it fills the window with a repeating byte pattern of odd length and reads the window back, comparing every byte. It then moves the pattern's starting phase on by one entry and runs the fill and the read-back again. This repeats once for each entry of the pattern. Because the pattern length is odd and the phase rotates, neighbouring addresses and addresses a power of two apart see different values. Decoder faults and page aliasing therefore show up alongside stuck data bits.

A parameter picks one of two pattern tables. The long table suits RAMs organised one bit wide. The short table suits RAMs organised four or eight bits wide. The engine stops at the first mismatch and holds the failing address and the expected byte until the next run.

Top module: `bpbist_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, fail_o, mem_we_o and mem_re_o are all 0.
- R2: If last_addr_i is below first_addr_i when a run is started, done_o pulses on the next cycle with fail_o = 1, fault_addr_o = 0 and fault_exp_o = 0. No RAM access is made.
- R3: Each fill pass writes exactly last_addr_i − first_addr_i + 1 bytes, to ascending addresses from first_addr_i through last_addr_i.
- R4: The k-th byte (counting from 0) of the pass with phase p carries table[(p + k) mod L]. With BIT_MODE=1, L=17 and the table is 0x00, then 0x01<<i for i=0..7, then the bitwise inverse of 0x01<<i for i=0..7. With BIT_MODE=0, L=9 and the table is 0x00, 0x11, 0x22, 0x44, 0x88, 0xEE, 0xDD, 0xBB, 0x77.
- R5: After each fill pass, the read-back pass reads the same addresses in the same order. It compares the mem_rdata_i returned one cycle after each read against the byte that was written there.
- R6: On the first mismatch the engine stops accessing the RAM and ends the run with fail_o = 1. fault_addr_o holds the mismatching address and fault_exp_o holds the expected byte.
- R7: The phase starts at 0 and rises by one after each clean read-back pass. Exactly L passes run. If all of them are clean, the run ends with fail_o = 0.
- R8: A start_i pulse while busy_o is 1 is ignored and does not change the addresses or the result of the run in progress.
- R9: busy_o rises on the cycle after an accepted start_i and stays high through the done cycle. done_o lasts exactly one cycle. fail_o, fault_addr_o and fault_exp_o hold until the next accepted start_i.
- R10: mem_we_o and mem_re_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| first_addr_i | input | AW | Lowest address of the window |
| last_addr_i | input | AW | Highest address of the window |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | Run failed (bad window or mismatch) |
| fault_addr_o | output | AW | Address of the first mismatch |
| fault_exp_o | output | 8 | Byte expected at the first mismatch |
| mem_addr_o | output | AW | RAM address |
| mem_wdata_o | output | 8 | RAM write data |
| mem_we_o | output | 1 | RAM write enable |
| mem_re_o | output | 1 | RAM read enable |
| mem_rdata_i | input | 8 | RAM read data, one cycle after mem_re_o |

## Verification
The engine is tried against a fault-free RAM over a wide window, over a single-byte window and over a reversed window. These runs separate the full pass sequence, the wrap of the pattern index and the early exit. It is then tried against a stuck-at-one bit in the middle of the window, the same fault at the last address (caught only in the drain cycle after the final read), and a write that also lands on a lower address. The mismatch each fault produces depends on the rotating phase, so the reported address and expected byte pin down the pattern order. The short-table variant runs a clean pass sequence alongside. A start pulse arriving mid-run shows that a busy engine ignores new commands.

// File: rtl/bpbist_pkg.sv
package bpbist_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WRITE = 3'd1,
    ST_READ  = 3'd2,
    ST_DRAIN = 3'd3,
    ST_FIN   = 3'd4
  } bp_state_e;

  function automatic int unsigned pat_len(input bit bit_mode);
    return bit_mode ? 17 : 9;
  endfunction

endpackage

// File: rtl/bpbist_table.sv
module bpbist_table #(
  parameter bit BIT_MODE = 1'b1,
  parameter int IW       = 5
) (
  input  logic [IW-1:0] idx_i,
  output logic [7:0]    data_o
);

  generate
    if (BIT_MODE) begin : g_walk_bit
      always_comb begin
        data_o = 8'h00;
        if (idx_i >= IW'(1) && idx_i <= IW'(8)) begin
          data_o = 8'h01 << (idx_i - IW'(1));
        end else if (idx_i >= IW'(9) && idx_i <= IW'(16)) begin
          data_o = ~(8'h01 << (idx_i - IW'(9)));
        end
      end
    end else begin : g_walk_nib
      always_comb begin
        data_o = 8'h00;
        if (idx_i >= IW'(1) && idx_i <= IW'(4)) begin
          data_o = 8'h11 << (idx_i - IW'(1));
        end else if (idx_i >= IW'(5) && idx_i <= IW'(8)) begin
          data_o = ~(8'h11 << (idx_i - IW'(5)));
        end
      end
    end
  endgenerate

endmodule

// File: rtl/bpbist_walker.sv
module bpbist_walker #(
  parameter int AW   = 16,
  parameter int PLEN = 17,
  parameter int IW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          adv_phase_i,
  input  logic          clr_phase_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] span_i,
  output logic [AW-1:0] addr_o,
  output logic [IW-1:0] idx_o,
  output logic          last_o,
  output logic          last_phase_o
);

  localparam logic [IW-1:0] LAST_IDX = IW'(PLEN - 1);

  logic [AW-1:0] addr_q, addr_d;
  logic [AW-1:0] rem_q, rem_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [IW-1:0] ph_q, ph_d;
  logic          adv_en;

  assign adv_en = load_i | step_i;

  always_comb begin
    ph_d = ph_q;
    if (clr_phase_i)      ph_d = '0;
    else if (adv_phase_i) ph_d = (ph_q == LAST_IDX) ? '0 : ph_q + IW'(1);
  end

  always_comb begin
    addr_d = addr_q;
    rem_d  = rem_q;
    idx_d  = idx_q;
    if (load_i) begin
      addr_d = base_i;
      rem_d  = span_i;
      idx_d  = ph_d;
    end else if (step_i) begin
      addr_d = addr_q + AW'(1);
      rem_d  = rem_q - AW'(1);
      idx_d  = (idx_q == LAST_IDX) ? '0 : idx_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
      idx_q  <= '0;
    end else if (adv_en) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
      idx_q  <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           ph_q <= '0;
    else if (clr_phase_i | adv_phase_i)   ph_q <= ph_d;
  end

  assign addr_o       = addr_q;
  assign idx_o        = idx_q;
  assign last_o       = (rem_q == '0);
  assign last_phase_o = (ph_q == LAST_IDX);

  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX);

  assert_phase_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= LAST_IDX);

  assert_step_ascend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (addr_o == $past(addr_o) + AW'(1)));

endmodule

// File: rtl/bpbist_ctrl.sv
module bpbist_ctrl
  import bpbist_pkg::*;
#(
  parameter int AW       = 16,
  parameter bit BIT_MODE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] first_addr_i,
  input  logic [AW-1:0] last_addr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [AW-1:0] fault_addr_o,
  output logic [7:0]    fault_exp_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  input  logic [7:0]    mem_rdata_i
);

  localparam int PLEN = pat_len(BIT_MODE);
  localparam int IW   = $clog2(PLEN);

  bp_state_e     state_q, state_d;
  logic [AW-1:0] base_q, span_q;
  logic [AW-1:0] base_sel, span_sel;
  logic          accept, range_bad, mismatch;
  logic          ld, stp, adv, clr;
  logic [AW-1:0] cur_addr;
  logic [IW-1:0] cur_idx;
  logic          last_byte, last_phase;
  logic [7:0]    pat_byte;
  logic          rd_vld_q;
  logic [AW-1:0] rd_addr_q;
  logic [7:0]    rd_exp_q;
  logic          fail_q;
  logic [AW-1:0] fa_q;
  logic [7:0]    fe_q;

  assign accept    = (state_q == ST_IDLE) && start_i;
  assign range_bad = (last_addr_i < first_addr_i);
  assign mismatch  = rd_vld_q && (mem_rdata_i != rd_exp_q);
  assign base_sel  = (state_q == ST_IDLE) ? first_addr_i : base_q;
  assign span_sel  = (state_q == ST_IDLE) ? (last_addr_i - first_addr_i) : span_q;

  bpbist_walker #(.AW(AW), .PLEN(PLEN), .IW(IW)) u_walker (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (ld),
    .step_i       (stp),
    .adv_phase_i  (adv),
    .clr_phase_i  (clr),
    .base_i       (base_sel),
    .span_i       (span_sel),
    .addr_o       (cur_addr),
    .idx_o        (cur_idx),
    .last_o       (last_byte),
    .last_phase_o (last_phase)
  );

  bpbist_table #(.BIT_MODE(BIT_MODE), .IW(IW)) u_table (
    .idx_i  (cur_idx),
    .data_o (pat_byte)
  );

  always_comb begin
    state_d = state_q;
    ld = 1'b0; stp = 1'b0; adv = 1'b0; clr = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (range_bad) begin
            state_d = ST_FIN;
          end else begin
            clr = 1'b1; ld = 1'b1; state_d = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        if (last_byte) begin
          ld = 1'b1; state_d = ST_READ;
        end else begin
          stp = 1'b1;
        end
      end
      ST_READ: begin
        if (mismatch)       state_d = ST_FIN;
        else if (last_byte) state_d = ST_DRAIN;
        else                stp = 1'b1;
      end
      ST_DRAIN: begin
        if (mismatch || last_phase) begin
          state_d = ST_FIN;
        end else begin
          adv = 1'b1; ld = 1'b1; state_d = ST_WRITE;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      span_q <= '0;
    end else if (accept) begin
      base_q <= first_addr_i;
      span_q <= last_addr_i - first_addr_i;
    end
  end

  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_re_o    = (state_q == ST_READ) && !mismatch;
  assign mem_addr_o  = cur_addr;
  assign mem_wdata_o = pat_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_vld_q <= 1'b0;
    else        rd_vld_q <= mem_re_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_q <= '0;
      rd_exp_q  <= '0;
    end else if (mem_re_o) begin
      rd_addr_q <= cur_addr;
      rd_exp_q  <= pat_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
      fa_q   <= '0;
      fe_q   <= '0;
    end else if (accept) begin
      fail_q <= range_bad;
      fa_q   <= '0;
      fe_q   <= '0;
    end else if (mismatch) begin
      fail_q <= 1'b1;
      fa_q   <= rd_addr_q;
      fe_q   <= rd_exp_q;
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_FIN);
  assign fail_o       = fail_q;
  assign fault_addr_o = fa_q;
  assign fault_exp_o  = fe_q;

  assert_no_rw_clash_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_busy_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  assert_bad_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && range_bad) |=> (done_o && fail_o && !mem_we_o && !mem_re_o));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_we_o && !mem_re_o));

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(fail_o) && $stable(fault_addr_o) && $stable(fault_exp_o)));

endmodule

// File: tb/bpbist_ctrl_tb.sv
module bpbist_ctrl_tb;

  localparam int AW = 16;

  typedef struct {
    bit         fail;
    logic [15:0] addr;
    logic [7:0]  exp;
    string       req;
  } exp_item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic start, start8;
  logic [AW-1:0] fa_in, la_in;
  logic busy, done, fail;
  logic [AW-1:0] f_addr, m_addr;
  logic [7:0] f_exp, m_wd, m_rd;
  logic m_we, m_re;
  logic busy8, done8, fail8, m_we8, m_re8;
  logic [AW-1:0] f_addr8, m_addr8;
  logic [7:0] f_exp8, m_wd8, m_rd8;

  int n_chk = 0, n_bad = 0, cyc = 0;
  exp_item_t sb_q[$];

  logic [7:0] ram [0:1023];
  logic [7:0] ram8 [0:1023];
  logic [7:0] refm [0:1023];
  bit stuck_on = 0, alias_on = 0;
  int stuck_a = 0, alias_src = 0, alias_dst = 0;
  logic [7:0] stuck_m = 8'h00;

  int mon_base = 0, mon_n = 1, wcnt = 0, rcnt = 0, acc_cnt = 0;
  int mon8_base = 0, mon8_n = 1, wcnt8 = 0;

  always #2.5 clk = ~clk;

  bpbist_ctrl #(.AW(AW), .BIT_MODE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .first_addr_i(fa_in), .last_addr_i(la_in),
    .busy_o(busy), .done_o(done), .fail_o(fail), .fault_addr_o(f_addr), .fault_exp_o(f_exp),
    .mem_addr_o(m_addr), .mem_wdata_o(m_wd), .mem_we_o(m_we), .mem_re_o(m_re), .mem_rdata_i(m_rd));

  bpbist_ctrl #(.AW(AW), .BIT_MODE(1'b0)) u_dut8 (
    .clk(clk), .rst_n(rst_n), .start_i(start8), .first_addr_i(fa_in), .last_addr_i(la_in),
    .busy_o(busy8), .done_o(done8), .fail_o(fail8), .fault_addr_o(f_addr8), .fault_exp_o(f_exp8),
    .mem_addr_o(m_addr8), .mem_wdata_o(m_wd8), .mem_we_o(m_we8), .mem_re_o(m_re8), .mem_rdata_i(m_rd8));

  always @(posedge clk) begin
    if (m_we) begin
      ram[m_addr[9:0]] <= m_wd;
      if (alias_on && int'(m_addr[9:0]) == alias_src) ram[alias_dst] <= m_wd;
    end
    if (m_re)
      m_rd <= ram[m_addr[9:0]] | ((stuck_on && int'(m_addr[9:0]) == stuck_a) ? stuck_m : 8'h00);
    if (m_we8) ram8[m_addr8[9:0]] <= m_wd8;
    if (m_re8) m_rd8 <= ram8[m_addr8[9:0]];
  end

  function automatic logic [7:0] tbl(input bit bm, input int i);
    if (bm) begin
      if (i == 0) return 8'h00;
      if (i <= 8) return 8'h01 << (i - 1);
      return ~(8'h01 << (i - 9));
    end else begin
      if (i == 0) return 8'h00;
      if (i <= 4) return 8'h11 << (i - 1);
      return ~(8'h11 << (i - 5));
    end
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  // Reference of the whole run from the requirements, with the same fault models as the RAM
  task automatic ref_run(input int s, input int e, output exp_item_t it);
    int n;
    logic [7:0] v, rd;
    n = e - s + 1;
    it.fail = 0; it.addr = '0; it.exp = '0;
    for (int p = 0; p < 17; p++) begin
      for (int k = 0; k < n; k++) begin
        v = tbl(1'b1, (p + k) % 17);
        refm[s + k] = v;
        if (alias_on && (s + k) == alias_src) refm[alias_dst] = v;
      end
      for (int k = 0; k < n; k++) begin
        v  = tbl(1'b1, (p + k) % 17);
        rd = refm[s + k] | ((stuck_on && (s + k) == stuck_a) ? stuck_m : 8'h00);
        if (rd != v) begin
          it.fail = 1; it.addr = 16'(s + k); it.exp = v;
          return;
        end
      end
    end
  endtask

  // Monitor: pops the scoreboard at each end-of-run pulse and checks the write/read streams
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_we || m_re) acc_cnt++;
      if (m_we) begin
        chk(int'(m_addr) == mon_base + (wcnt % mon_n), "R3", "write address", int'(m_addr), mon_base + (wcnt % mon_n));
        chk(m_wd == tbl(1'b1, ((wcnt / mon_n) + (wcnt % mon_n)) % 17), "R4", "write data",
            int'(m_wd), int'(tbl(1'b1, ((wcnt / mon_n) + (wcnt % mon_n)) % 17)));
        wcnt++;
      end
      if (m_re) begin
        chk(int'(m_addr) == mon_base + (rcnt % mon_n), "R5", "read address", int'(m_addr), mon_base + (rcnt % mon_n));
        rcnt++;
      end
      if (m_we8) begin
        chk(m_wd8 == tbl(1'b0, ((wcnt8 / mon8_n) + (wcnt8 % mon8_n)) % 9), "R4", "nibble-table write data",
            int'(m_wd8), int'(tbl(1'b0, ((wcnt8 / mon8_n) + (wcnt8 % mon8_n)) % 9)));
        wcnt8++;
      end
      if (done) begin
        if (sb_q.size() == 0) begin
          chk(0, "R9", "unexpected done", 1, 0);
        end else begin
          exp_item_t it;
          it = sb_q.pop_front();
          chk(fail == it.fail, it.req, "fail", int'(fail), int'(it.fail));
          chk(f_addr == it.addr, it.req, "fault address", int'(f_addr), int'(it.addr));
          chk(f_exp == it.exp, it.req, "fault expected byte", int'(f_exp), int'(it.exp));
        end
      end
    end
  end

  // Driver: queues the expected result, starts a run and waits for its end
  task automatic run(input int s, input int e, input string req, input bit poke);
    exp_item_t it;
    int w;
    if (e < s) begin
      it.fail = 1; it.addr = '0; it.exp = '0;
    end else begin
      ref_run(s, e, it);
    end
    it.req = req;
    sb_q.push_back(it);
    mon_base = s; mon_n = (e >= s) ? e - s + 1 : 1; wcnt = 0; rcnt = 0; acc_cnt = 0;
    @(negedge clk);
    fa_in = 16'(s); la_in = 16'(e); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9", "busy after start", int'(busy), 1);
    w = 0;
    while (!done) begin
      @(negedge clk);
      w++;
      if (poke && w == 20) begin
        fa_in = 16'h0050; la_in = 16'h0010; start = 1'b1;
      end else if (poke && w == 21) begin
        start = 1'b0; fa_in = 16'(s); la_in = 16'(e);
      end
    end
    if (e < s) chk(acc_cnt == 0, "R2", "accesses on reversed window", acc_cnt, 0);
    if (e >= s && !it.fail)
      chk(wcnt == 17 * mon_n, "R7", "total writes", wcnt, 17 * mon_n);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done width", int'(done), 0);
    chk(busy == 1'b0, "R9", "busy after done", int'(busy), 0);
    repeat (3) @(negedge clk);
    chk(fail == it.fail && f_addr == it.addr, "R6", "result held", int'(f_addr), int'(it.addr));
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=%0d expected<150000", cyc);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; start8 = 1'b0; fa_in = '0; la_in = '0;
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1", "busy at reset", int'(busy), 0);
    chk(done == 0, "R1", "done at reset", int'(done), 0);
    chk(fail == 0, "R1", "fail at reset", int'(fail), 0);
    chk(m_we == 0 && m_re == 0, "R1", "ram strobes at reset", int'({m_we, m_re}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(16'h100, 16'h12A, "R7", 0);
    run(16'h200, 16'h200, "R3", 0);
    run(16'h050, 16'h04F, "R2", 0);
    stuck_on = 1; stuck_a = 16'h105; stuck_m = 8'h10;
    run(16'h100, 16'h12A, "R6", 0);
    stuck_a = 16'h12A; stuck_m = 8'h80;
    run(16'h100, 16'h12A, "R5", 0);
    stuck_on = 0;
    alias_on = 1; alias_src = 16'h310; alias_dst = 16'h308;
    run(16'h300, 16'h320, "R6", 0);
    alias_on = 0;
    run(16'h100, 16'h11F, "R8", 1);

    // nibble-table variant, clean run
    mon8_base = 16'h040; mon8_n = 32; wcnt8 = 0;
    @(negedge clk);
    fa_in = 16'h040; la_in = 16'h05F; start8 = 1'b1;
    @(negedge clk);
    start8 = 1'b0;
    while (!done8) @(negedge clk);
    chk(fail8 == 1'b0, "R7", "nibble-table clean result", int'(fail8), 0);
    chk(wcnt8 == 9 * 32, "R4", "nibble-table write count", wcnt8, 288);

    chk(sb_q.size() == 0, "R9", "scoreboard drained", sb_q.size(), 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule